// File: doc/BRIEF.md
# Seconds Time Counter with Alarm

This block is a memory-mapped real-time clock core. It keeps a 32-bit count of seconds that advances on an external once-per-second pulse. It compares that count against a programmable alarm value, and it raises a per-second event and an alarm event. Each event has a write-one-to-clear status bit. Each event also has an enable bit, which is set through one register and cleared through another. A single interrupt line is the OR of every pending status bit whose enable bit is set.

Software loads a new time in two steps. The written value first goes to a staging register, where it can be read back at once. The current time keeps running. On the next second pulse the staged value replaces the current time, and that same pulse sets the per-second status bit. Software can therefore clear bit 0 after a load and use it later to tell whether the load has taken effect. A small timebase state machine tracks whether a load is waiting. It has two states: `TB_FREE` (no load pending) and `TB_STAGED` (a staged value waits for the next pulse). The transitions are named as follows:
- `FREE->STAGED`: a set-time write.
- `STAGED->STAGED`: a further set-time write, which overwrites the staged value.
- `STAGED->FREE`: a second pulse with no write in the same cycle.

The core also holds the following:
- a calibration word;
- a cycle counter that measures the time since the last second boundary;
- two plain control bits, for battery switchover and oscillator enable, which are driven out as pins.

Top module: `sec_time_core`

## Requirements
- R1: After reset the following hold:
  - the current time, staged time, alarm, status, enable mask and control all read 0;
  - the calibration word reads its reset default, 0x198233;
  - `irq` is low.
- R2: With no load pending, each cycle with `sec_pulse` high adds one to the current time (offset 0x10). The count wraps from 0xFFFFFFFF to 0. Without a pulse, the time holds.
- R3: A write to offset 0x00 stores the value as the staged time. The staged time reads back at offset 0x04 from the next cycle. The current time is unchanged until the next pulse, which copies the staged value into it and ends the pending state.
- R4: When a set-time write and a pulse fall in the same cycle, the pulse acts on the earlier state (it loads the earlier staged value or increments). The newly written value stays pending for the following pulse.
- R5: Offset 0x18 holds the alarm time. Status bit 1 is set by a pulse whose new current time equals the alarm, whether that time comes from an increment or from a load. Writing an alarm equal to the present time sets nothing.
- R6: Status is read at offset 0x20: bit 0 is the second event and bit 1 is the alarm event. Every pulse sets bit 0. Writing 1 to a status bit clears it, and writing 0 has no effect. An event in the same cycle as the clear keeps the bit set.
- R7: Writing 1 to a bit at offset 0x28 enables that event. Writing 1 to a bit at offset 0x2C disables it. Zero bits leave the enable unchanged. The enable mask reads at offset 0x24.
- R8: Status bits are set regardless of the mask. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: At offset 0x40, bit 31 (battery switchover) and bit 24 (oscillator enable) are read/write bits. They drive `ctrl_batt_en` and `ctrl_osc_en`. All other bits of this register read 0.
- R10: Offset 0x08 takes a 21-bit calibration word, which reads back at offset 0x0C. Offset 0x14 reads a cycle counter with these rules:
  - the counter is zeroed by every pulse and by every calibration write;
  - it increases by one on each other cycle;
  - it saturates at its maximum value.
- R11: Reads of offsets 0x00, 0x08, 0x28, 0x2C and of unmapped offsets return 0. Writes to unmapped offsets and to offsets 0x04, 0x0C, 0x10, 0x14 and 0x24 change nothing.
- R12: `bus_rdata` takes the addressed value one clock after a cycle with `bus_rd` high, as seen before that edge. Otherwise `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_pulse | input | 1 | One-cycle pulse at each second boundary |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| ctrl_batt_en | output | 1 | Battery switchover enable bit |
| ctrl_osc_en | output | 1 | Oscillator enable bit |

## Verification
The staging state is the one most likely to go wrong. A lost or stuck pending state shows at the first pulse after a set-time write: the time at 0x10 increments when it should load, or keeps reloading when it should count. A wrong status or mask bit shows on `irq` in the same cycle that the register settles, and a status read makes it visible one clock after the read strobe. A wrong alarm compare shows only on the pulse that reaches the alarm value. For this reason the bench steps the time across the alarm, and across the wrap, one pulse at a time.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int DATA_W = 32;
    localparam int EVT_N  = 2;
    localparam int EVT_SEC = 0;
    localparam int EVT_ALM = 1;
    localparam int CTRL_BATT_BIT = 31;
    localparam int CTRL_OSC_BIT  = 24;

    // Byte offsets; software depends on these positions.
    localparam logic [7:0] OFF_SET_WR  = 8'h00;
    localparam logic [7:0] OFF_SET_RD  = 8'h04;
    localparam logic [7:0] OFF_CAL_WR  = 8'h08;
    localparam logic [7:0] OFF_CAL_RD  = 8'h0C;
    localparam logic [7:0] OFF_TIME    = 8'h10;
    localparam logic [7:0] OFF_TICK    = 8'h14;
    localparam logic [7:0] OFF_ALARM   = 8'h18;
    localparam logic [7:0] OFF_STATUS  = 8'h20;
    localparam logic [7:0] OFF_MASK    = 8'h24;
    localparam logic [7:0] OFF_ENABLE  = 8'h28;
    localparam logic [7:0] OFF_DISABLE = 8'h2C;
    localparam logic [7:0] OFF_CTRL    = 8'h40;

    typedef enum logic {
        TB_FREE   = 1'b0,
        TB_STAGED = 1'b1
    } tb_state_e;
endpackage

// File: rtl/sct_timebase.sv
module sct_timebase
    import sct_pkg::*;
#(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_pulse,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick_clr,
    input  logic [DATA_W-1:0] alarm_val,
    output logic [DATA_W-1:0] cur_time,
    output logic [DATA_W-1:0] staged_time,
    output logic              pending,
    output logic [TICK_W-1:0] tick_cnt,
    output logic              sec_evt,
    output logic              alm_evt
);
    localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

    tb_state_e         state, state_nxt;
    logic [DATA_W-1:0] time_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TB_FREE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            TB_FREE:   if (load_wr) state_nxt = TB_STAGED;
            TB_STAGED: begin
                if (load_wr)        state_nxt = TB_STAGED;
                else if (sec_pulse) state_nxt = TB_FREE;
            end
            default:   state_nxt = TB_FREE;
        endcase
    end

    // State outputs
    always_comb begin
        time_nxt = cur_time + 1'b1;
        pending  = 1'b0;
        unique case (state)
            TB_FREE:   time_nxt = cur_time + 1'b1;
            TB_STAGED: begin
                time_nxt = staged_time;
                pending  = 1'b1;
            end
            default:   time_nxt = cur_time + 1'b1;
        endcase
    end

    assign sec_evt = sec_pulse;
    assign alm_evt = sec_pulse && (time_nxt == alarm_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_time    <= '0;
            staged_time <= '0;
            tick_cnt    <= '0;
        end else begin
            if (sec_pulse) cur_time <= time_nxt;
            if (load_wr)   staged_time <= load_val;
            if (sec_pulse || tick_clr)  tick_cnt <= '0;
            else if (tick_cnt != TICK_MAX) tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sct_events.sv
module sct_events
    import sct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             clr_wr,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [EVT_N-1:0] wbits,
    output logic [EVT_N-1:0] sts,
    output logic [EVT_N-1:0] mask,
    output logic             irq
);
    for (genvar i = 0; i < EVT_N; i++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts[i]  <= 1'b0;
                mask[i] <= 1'b0;
            end else begin
                // a same-cycle event overrides the clear
                sts[i] <= evt[i] | (sts[i] & ~(clr_wr & wbits[i]));
                if (en_wr && wbits[i])       mask[i] <= 1'b1;
                else if (dis_wr && wbits[i]) mask[i] <= 1'b0;
            end
        end
    end

    assign irq = |(sts & mask);
endmodule

// File: rtl/sct_regfile.sv
module sct_regfile
    import sct_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              TICK_W  = 16,
    parameter int              CAL_W   = 21,
    parameter logic [CAL_W-1:0] CAL_RST = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] staged_time,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic [EVT_N-1:0]  sts,
    input  logic [EVT_N-1:0]  mask,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] alarm_val,
    output logic              set_wr,
    output logic              cal_wr,
    output logic              clr_wr,
    output logic              en_wr,
    output logic              dis_wr,
    output logic              batt_en,
    output logic              osc_en
);
    logic [CAL_W-1:0] cal_word;
    logic             alarm_wr, ctrl_wr;

    always_comb begin
        set_wr   = wr && (addr == ADDR_W'(OFF_SET_WR));
        cal_wr   = wr && (addr == ADDR_W'(OFF_CAL_WR));
        alarm_wr = wr && (addr == ADDR_W'(OFF_ALARM));
        clr_wr   = wr && (addr == ADDR_W'(OFF_STATUS));
        en_wr    = wr && (addr == ADDR_W'(OFF_ENABLE));
        dis_wr   = wr && (addr == ADDR_W'(OFF_DISABLE));
        ctrl_wr  = wr && (addr == ADDR_W'(OFF_CTRL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_word  <= CAL_RST;
            alarm_val <= '0;
            batt_en   <= 1'b0;
            osc_en    <= 1'b0;
        end else begin
            if (cal_wr)   cal_word  <= wdata[CAL_W-1:0];
            if (alarm_wr) alarm_val <= wdata;
            if (ctrl_wr) begin
                batt_en <= wdata[CTRL_BATT_BIT];
                osc_en  <= wdata[CTRL_OSC_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            case (addr)
                ADDR_W'(OFF_SET_RD): rdata <= staged_time;
                ADDR_W'(OFF_CAL_RD): rdata <= DATA_W'(cal_word);
                ADDR_W'(OFF_TIME):   rdata <= cur_time;
                ADDR_W'(OFF_TICK):   rdata <= DATA_W'(tick_cnt);
                ADDR_W'(OFF_ALARM):  rdata <= alarm_val;
                ADDR_W'(OFF_STATUS): rdata <= DATA_W'(sts);
                ADDR_W'(OFF_MASK):   rdata <= DATA_W'(mask);
                ADDR_W'(OFF_CTRL): begin
                    rdata <= '0;
                    rdata[CTRL_BATT_BIT] <= batt_en;
                    rdata[CTRL_OSC_BIT]  <= osc_en;
                end
                default:             rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sec_time_core.sv
module sec_time_core
    import sct_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              TICK_W  = 16,
    parameter int              CAL_W   = 21,
    parameter logic [CAL_W-1:0] CAL_RST = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              ctrl_batt_en,
    output logic              ctrl_osc_en
);
    logic [DATA_W-1:0] cur_time, staged_time, alarm_val;
    logic [TICK_W-1:0] tick_cnt;
    logic              pending, sec_evt, alm_evt;
    logic              set_wr, cal_wr, sts_clr_wr, en_wr, dis_wr;
    logic [EVT_N-1:0]  sts, mask, evt;

    assign evt[EVT_SEC] = sec_evt;
    assign evt[EVT_ALM] = alm_evt;

    sct_timebase #(.TICK_W(TICK_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
        .load_wr(set_wr), .load_val(bus_wdata), .tick_clr(cal_wr),
        .alarm_val(alarm_val), .cur_time(cur_time), .staged_time(staged_time),
        .pending(pending), .tick_cnt(tick_cnt), .sec_evt(sec_evt), .alm_evt(alm_evt)
    );

    sct_events u_events (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_wr(sts_clr_wr),
        .en_wr(en_wr), .dis_wr(dis_wr), .wbits(bus_wdata[EVT_N-1:0]),
        .sts(sts), .mask(mask), .irq(irq)
    );

    sct_regfile #(
        .ADDR_W(ADDR_W), .TICK_W(TICK_W), .CAL_W(CAL_W), .CAL_RST(CAL_RST)
    ) u_regfile (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .cur_time(cur_time), .staged_time(staged_time),
        .tick_cnt(tick_cnt), .sts(sts), .mask(mask), .rdata(bus_rdata),
        .alarm_val(alarm_val), .set_wr(set_wr), .cal_wr(cal_wr),
        .clr_wr(sts_clr_wr), .en_wr(en_wr), .dis_wr(dis_wr),
        .batt_en(ctrl_batt_en), .osc_en(ctrl_osc_en)
    );
endmodule

// File: rtl/sct_checker.sv
module sct_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sec_pulse,
    input logic        set_wr,
    input logic        sts_clr_wr,
    input logic [31:0] wdata,
    input logic [31:0] cur_time,
    input logic [31:0] staged_time,
    input logic        pending,
    input logic [1:0]  sts,
    input logic [1:0]  mask,
    input logic        irq
);
    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !pending) |=> (cur_time == $past(cur_time) + 32'd1));

    assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_pulse |=> $stable(cur_time));

    assert_load_staged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && pending) |=> (cur_time == $past(staged_time)));

    assert_write_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> pending);

    assert_load_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !set_wr) |=> !pending);

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> sts[0]);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr_wr && wdata[0] && !sec_pulse) |=> !sts[0]);

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq);
endmodule

bind sec_time_core sct_checker u_sct_checker (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .set_wr(set_wr),
    .sts_clr_wr(sts_clr_wr), .wdata(bus_wdata), .cur_time(cur_time),
    .staged_time(staged_time), .pending(pending), .sts(sts), .mask(mask),
    .irq(irq)
);

// File: tb/test_sec_time_core.sv
module test_sec_time_core;
    localparam int TICK_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_pulse = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, ctrl_batt_en, ctrl_osc_en;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sec_time_core #(.TICK_W(TICK_W)) i_sec_time_core (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .ctrl_batt_en(ctrl_batt_en),
        .ctrl_osc_en(ctrl_osc_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse();
        sec_pulse = 1'b1;
        step();
        sec_pulse = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h10, d); check("R1 time", d, 0);
        rd(8'h04, d); check("R1 staged", d, 0);
        rd(8'h18, d); check("R1 alarm", d, 0);
        rd(8'h20, d); check("R1 status", d, 0);
        rd(8'h24, d); check("R1 mask", d, 0);
        rd(8'h40, d); check("R1 ctrl", d, 0);
        rd(8'h0C, d); check("R1 cal", d, 32'h198233);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        pulse(); pulse(); pulse();
        step(); step();
        rd(8'h10, d); check("R2 count", d, 3);
    endtask

    task automatic t_stage();
        logic [31:0] d;
        wr(8'h00, 32'd1000);
        rd(8'h04, d); check("R3 readback", d, 1000);
        rd(8'h10, d); check("R3 time before pulse", d, 3);
        pulse();
        rd(8'h10, d); check("R3 loaded", d, 1000);
        pulse();
        rd(8'h10, d); check("R3 counts after load", d, 1001);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(8'h00, 32'd50);
        bus_addr = 8'h00; bus_wdata = 32'd70; bus_wr = 1'b1; sec_pulse = 1'b1;
        step();
        bus_wr = 1'b0; sec_pulse = 1'b0;
        rd(8'h10, d); check("R4 old staged loaded", d, 50);
        rd(8'h04, d); check("R4 new staged", d, 70);
        pulse();
        rd(8'h10, d); check("R4 new loaded next", d, 70);
        bus_addr = 8'h00; bus_wdata = 32'd90; bus_wr = 1'b1; sec_pulse = 1'b1;
        step();
        bus_wr = 1'b0; sec_pulse = 1'b0;
        rd(8'h10, d); check("R4 free increments", d, 71);
        pulse();
        rd(8'h10, d); check("R4 free then loads", d, 90);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        pulse();
        rd(8'h10, d); check("R2 max", d, 32'hFFFF_FFFF);
        pulse();
        rd(8'h10, d); check("R2 wrap", d, 0);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr(8'h00, 32'd100);
        pulse();
        wr(8'h20, 32'h3);
        wr(8'h18, 32'd100);
        rd(8'h20, d); check("R5 equal write no fire", d, 0);
        wr(8'h18, 32'd102);
        rd(8'h18, d); check("R5 alarm readback", d, 102);
        pulse();
        rd(8'h20, d); check("R5 no alarm at 101", d, 1);
        pulse();
        rd(8'h20, d); check("R5 alarm at 102", d, 3);
        wr(8'h20, 32'h3);
        wr(8'h00, 32'd102);
        pulse();
        rd(8'h20, d); check("R5 alarm on load", d, 3);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h20, 32'h0);
        rd(8'h20, d); check("R6 zero write keeps", d, 3);
        wr(8'h20, 32'h2);
        rd(8'h20, d); check("R6 clear alarm only", d, 1);
        bus_addr = 8'h20; bus_wdata = 32'h1; bus_wr = 1'b1; sec_pulse = 1'b1;
        step();
        bus_wr = 1'b0; sec_pulse = 1'b0;
        rd(8'h20, d); check("R6 event wins", d, 1);
        wr(8'h20, 32'h1);
        rd(8'h20, d); check("R6 cleared", d, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        check("R8 idle irq", {31'd0, irq}, 0);
        wr(8'h28, 32'h2);
        rd(8'h24, d); check("R7 enable alarm", d, 2);
        wr(8'h28, 32'h1);
        rd(8'h24, d); check("R7 enable sec", d, 3);
        wr(8'h2C, 32'h2);
        rd(8'h24, d); check("R7 disable alarm", d, 1);
        rd(8'h28, d); check("R11 enable reads 0", d, 0);
        check("R8 no status no irq", {31'd0, irq}, 0);
        pulse();
        check("R8 irq raised", {31'd0, irq}, 1);
        wr(8'h2C, 32'h1);
        check("R8 masked irq low", {31'd0, irq}, 0);
        rd(8'h20, d); check("R8 status despite mask", d, 1);
        wr(8'h20, 32'h3);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); check("R9 both bits", d, 32'h8100_0000);
        check("R9 pins", {30'd0, ctrl_batt_en, ctrl_osc_en}, 3);
        wr(8'h40, 32'h0100_0000);
        rd(8'h40, d); check("R9 osc only", d, 32'h0100_0000);
    endtask

    task automatic t_cal_tick();
        logic [31:0] d;
        wr(8'h08, 32'hFFFF_FFFF);
        repeat (5) step();
        rd(8'h14, d); check("R10 tick after cal", d, 5);
        rd(8'h0C, d); check("R10 cal readback", d, 32'h1F_FFFF);
        rd(8'h08, d); check("R11 cal write reads 0", d, 0);
        repeat (300) step();
        rd(8'h14, d); check("R10 tick saturates", d, 255);
        pulse();
        repeat (2) step();
        rd(8'h14, d); check("R10 pulse clears tick", d, 2);
    endtask

    task automatic t_unmapped();
        logic [31:0] d, t0;
        rd(8'h10, t0);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, d); check("R11 unmapped reads 0", d, 0);
        wr(8'h10, 32'h1234);
        wr(8'h24, 32'h3);
        rd(8'h10, d); check("R11 time write ignored", d, t0);
        rd(8'h24, d); check("R11 mask write ignored", d, 0);
        rd(8'h00, d); check("R11 set-time reads 0", d, 0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        rd(8'h10, d);
        pulse();
        check("R12 rdata holds", bus_rdata, d);
        rd(8'h10, d); check("R12 new read", d, bus_rdata);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_count();
        t_stage();
        t_collide();
        t_wrap();
        t_alarm();
        t_w1c();
        t_mask();
        t_ctrl();
        t_cal_tick();
        t_unmapped();
        t_latency();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule